// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block turns an asynchronous serial line into bytes. The line carries frames of the usual 8N1 shape. The line rests high. A low start bit opens each frame. Eight data bits follow, least significant first, and a high stop bit closes the frame. The receiver has no copy of the transmitter's clock, so it looks at the line once on every pulse of an oversampling tick. That tick runs at eight times the bit rate and comes from a baud generator outside the block.

Every sample first passes through a synchronizer chain. A small saturating up/down counter then smooths it, and the cleaned line only changes after the counter has reached one of its two ends. The receiver aligns to the falling edge of the start bit on the cleaned line. It then samples near the middle of each bit, shifts the bits into the data bus as they arrive, and checks the stop bit. While a frame is arriving, the data bus shows a partly filled value. The bus is valid only in the clock cycle in which the strobe is high. That strobe lasts exactly one clock for each good frame.

Top module: `orx_receiver`

## Requirements
- R1: After reset, `rx_valid` is 0 and `rx_data` is 0.
- R2: With `os_tick` low, no state moves: a change on `rx_line` has no effect, `rx_data` holds, and `rx_valid` stays 0.
- R3: A line pulse that lasts one oversample and is opposite to the surrounding level is filtered out. On an idle line it starts no frame. Inside a data bit it leaves the received byte unchanged.
- R4: A frame made of one low start bit, eight data bits with bit 0 sent first, and a high stop bit, each bit lasting eight ticks, yields that byte on `rx_data`.
- R5: For each accepted frame, `rx_valid` is high for exactly one clock cycle. `rx_data` holds the byte during that cycle.
- R6: If the stop bit samples low, the byte is dropped and `rx_valid` stays 0. The receiver then waits for the line to go high before it can start a new frame, so a long low stretch after the bad stop bit produces no byte.
- R7: Frames sent back to back, with no idle time between the stop bit and the next start bit, are all recovered in order.
- R8: Bytes across the whole 0x00..0xFF range are recovered at a tick rate of a few clocks per tick as well as at the rate for 115200 baud.
- R9: A low pulse of four ticks on an idle line is a false start. It is rejected when the middle of the start bit samples high, and it yields no byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling enable, eight pulses per bit time |
| rx_line | input | 1 | Raw asynchronous serial input |
| rx_data | output | DATA_W | Received byte, filled as bits arrive |
| rx_valid | output | 1 | One-clock strobe when a complete byte is good |

## Verification
The assertions check, on every cycle, that the strobe never lasts more than one clock. They also check that nothing moves in a cycle without a tick, that the strobe follows only a stop bit that sampled high, and that a frame starts only from a low cleaned line. Only the bench's scenarios can show the rest. These are correct byte values, bit order, rejection of glitches and false starts, recovery across back-to-back frames, and the wait for a high line after a bad stop bit. Each of these depends on the exact shape of the stimulus over many ticks.

// File: rtl/orx_pkg.sv
package orx_pkg;
   typedef enum logic [2:0] {
      RX_IDLE  = 3'd0,
      RX_START = 3'd1,
      RX_DATA  = 3'd2,
      RX_STOP  = 3'd3,
      RX_DRAIN = 3'd4
   } rx_state_t;
endpackage

// File: rtl/orx_line_cond.sv
module orx_line_cond #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_W      = 2,
   parameter bit USE_FILTER  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic line_i,
   output logic bit_o
);
   localparam logic [FILT_W-1:0] CNT_TOP = '1;

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   sync_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else if (tick) sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
   end

   assign sync_bit = sync_q[SYNC_STAGES-1];

   generate
      if (USE_FILTER) begin : g_filter
         logic [FILT_W-1:0] cnt_q;
         logic              bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= CNT_TOP;
               bit_q <= 1'b1;
            end else if (tick) begin
               if (sync_bit && cnt_q != CNT_TOP) cnt_q <= cnt_q + 1'b1;
               else if (!sync_bit && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
               if (cnt_q == CNT_TOP) bit_q <= 1'b1;
               else if (cnt_q == '0) bit_q <= 1'b0;
            end
         end
         assign bit_o = bit_q;
      end else begin : g_direct
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bit_q <= 1'b1;
            else if (tick) bit_q <= sync_bit;
         end
         assign bit_o = bit_q;
      end
   endgenerate
endmodule

// File: rtl/orx_bit_timer.sv
module orx_bit_timer #(
   parameter int OVS_LOG2 = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic realign,
   output logic boundary
);
   localparam logic [OVS_LOG2-1:0] HALF = OVS_LOG2'(1 << (OVS_LOG2 - 1));
   localparam logic [OVS_LOG2-1:0] LAST = '1;

   logic [OVS_LOG2-1:0] spc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) spc_q <= '0;
      else if (tick) begin
         if (realign) spc_q <= HALF;
         else spc_q <= spc_q + 1'b1;
      end
   end

   assign boundary = (spc_q == LAST);
endmodule

// File: rtl/orx_frame_fsm.sv
module orx_frame_fsm #(
   parameter int DATA_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  tick,
   input  logic                  boundary,
   input  logic                  bit_i,
   output logic                  realign,
   output orx_pkg::rx_state_t    state_o,
   output logic [DATA_W-1:0]     data_o,
   output logic                  ready_o
);
   import orx_pkg::*;

   localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

   rx_state_t         state_q;
   logic [IDX_W-1:0]  idx_q;
   logic [DATA_W-1:0] shr_q;
   logic              rdy_q;

   assign realign = (state_q == RX_IDLE) && !bit_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RX_IDLE;
         idx_q   <= '0;
         shr_q   <= '0;
         rdy_q   <= 1'b0;
      end else begin
         rdy_q <= 1'b0;
         if (tick) begin
            case (state_q)
               RX_IDLE: if (!bit_i) state_q <= RX_START;
               RX_START: if (boundary) begin
                  idx_q   <= '0;
                  state_q <= bit_i ? RX_IDLE : RX_DATA;
               end
               RX_DATA: if (boundary) begin
                  shr_q <= {bit_i, shr_q[DATA_W-1:1]};
                  if (idx_q == IDX_LAST) state_q <= RX_STOP;
                  else idx_q <= idx_q + 1'b1;
               end
               RX_STOP: if (boundary) begin
                  if (bit_i) begin
                     rdy_q   <= 1'b1;
                     state_q <= RX_IDLE;
                  end else state_q <= RX_DRAIN;
               end
               RX_DRAIN: if (bit_i) state_q <= RX_IDLE;
               default: state_q <= RX_IDLE;
            endcase
         end
      end
   end

   assign state_o = state_q;
   assign data_o  = shr_q;
   assign ready_o = rdy_q;
endmodule

// File: rtl/orx_receiver.sv
module orx_receiver #(
   parameter int DATA_W      = 8,
   parameter int OVS_LOG2    = 3,
   parameter int SYNC_STAGES = 2,
   parameter int FILT_W      = 2,
   parameter bit USE_FILTER  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              os_tick,
   input  logic              rx_line,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid
);
   generate
      if (DATA_W < 2)      begin : g_bad_data $error("DATA_W must be at least 2"); end
      if (OVS_LOG2 < 2)    begin : g_bad_ovs  $error("OVS_LOG2 must be at least 2"); end
      if (SYNC_STAGES < 2) begin : g_bad_sync $error("SYNC_STAGES must be at least 2"); end
      if (FILT_W < 1)      begin : g_bad_filt $error("FILT_W must be at least 1"); end
   endgenerate

   logic               clean_bit;
   logic               realign;
   logic               boundary;
   orx_pkg::rx_state_t state_q;

   orx_line_cond #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_W     (FILT_W),
      .USE_FILTER (USE_FILTER)
   ) u_cond (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (os_tick),
      .line_i(rx_line),
      .bit_o (clean_bit)
   );

   orx_bit_timer #(.OVS_LOG2(OVS_LOG2)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (os_tick),
      .realign (realign),
      .boundary(boundary)
   );

   orx_frame_fsm #(.DATA_W(DATA_W)) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (os_tick),
      .boundary(boundary),
      .bit_i   (clean_bit),
      .realign (realign),
      .state_o (state_q),
      .data_o  (rx_data),
      .ready_o (rx_valid)
   );
endmodule

// File: rtl/orx_receiver_chk.sv
module orx_receiver_chk #(
   parameter int DATA_W = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               os_tick,
   input logic [DATA_W-1:0]  rx_data,
   input logic               rx_valid,
   input logic               clean_bit,
   input orx_pkg::rx_state_t state_q
);
   import orx_pkg::*;

   p_valid_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !os_tick |=> ($stable(rx_data) && $stable(clean_bit) && !rx_valid));

   p_stop_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> $past(clean_bit));

   p_valid_after_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> ($past(state_q) == RX_STOP && state_q == RX_IDLE));

   p_start_from_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == RX_START && $past(state_q) == RX_IDLE) |-> !$past(clean_bit));
endmodule

bind orx_receiver orx_receiver_chk #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .os_tick  (os_tick),
   .rx_data  (rx_data),
   .rx_valid (rx_valid),
   .clean_bit(clean_bit),
   .state_q  (state_q)
);

// File: tb/orx_receiver_tb.sv
module orx_receiver_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       os_tick = 1'b0;
   logic       rx_line = 1'b1;
   logic [7:0] rx_data;
   logic       rx_valid;

   int   div = 217;
   bit   tick_en = 1'b1;
   int   tcnt = 0;
   int   n_chk = 0;
   int   n_bad = 0;
   int   n_got = 0;
   int   exp_n = 0;
   logic [7:0] last_got = '0;
   bit   done = 1'b0;

   always #2.5 clk = ~clk;

   orx_receiver u_dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .os_tick (os_tick),
      .rx_line (rx_line),
      .rx_data (rx_data),
      .rx_valid(rx_valid)
   );

   always @(posedge clk) begin
      if (!tick_en) begin
         os_tick <= 1'b0;
      end else if (tcnt >= div - 1) begin
         tcnt    <= 0;
         os_tick <= 1'b1;
      end else begin
         tcnt    <= tcnt + 1;
         os_tick <= 1'b0;
      end
   end

   always @(negedge clk) begin
      if (rst_n && rx_valid) begin
         n_got    <= n_got + 1;
         last_got <= rx_data;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         while (!os_tick) @(negedge clk);
      end
   endtask

   task automatic drive(input logic v, input int n);
      rx_line = v;
      wait_ticks(n);
   endtask

   task automatic send_frame(input logic [7:0] b, input logic stop_v, input int glitch_bit);
      drive(1'b0, 8);
      for (int i = 0; i < 8; i++) begin
         if (i == glitch_bit) begin
            drive(b[i], 3);
            drive(~b[i], 1);
            drive(b[i], 4);
         end else begin
            drive(b[i], 8);
         end
      end
      drive(stop_v, 8);
   endtask

   task automatic expect_byte(input string tag, input logic [7:0] b);
      exp_n++;
      check(n_got == exp_n, {tag, " count"}, n_got, exp_n);
      check(last_got == b, {tag, " byte"}, last_got, b);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (10) @(negedge clk);
      // R1: reset state
      check(rx_valid == 1'b0, "R1 valid", rx_valid, 0);
      check(rx_data == 8'h00, "R1 data", rx_data, 0);
      rst_n = 1'b1;
      wait_ticks(12);

      // R4: 0x55 and 0xC4 at the 115200 baud tick rate
      send_frame(8'h55, 1'b1, -1); drive(1'b1, 4);
      expect_byte("R4 0x55", 8'h55);
      send_frame(8'hC4, 1'b1, -1); drive(1'b1, 4);
      expect_byte("R4 0xC4", 8'hC4);

      div = 5;
      wait_ticks(4);

      // R7: back-to-back frames
      send_frame(8'h55, 1'b1, -1);
      send_frame(8'hC4, 1'b1, -1);
      send_frame(8'h55, 1'b1, -1);
      drive(1'b1, 4);
      check(n_got == exp_n + 3, "R7 count", n_got, exp_n + 3);
      check(last_got == 8'h55, "R7 last byte", last_got, 8'h55);
      exp_n += 3;

      // R3: single-oversample glitch inside data bits
      send_frame(8'hC4, 1'b1, 7); drive(1'b1, 4);
      expect_byte("R3 glitch bit7", 8'hC4);
      send_frame(8'h55, 1'b1, 1); drive(1'b1, 4);
      expect_byte("R3 glitch bit1", 8'h55);

      // R3: single-oversample glitch on idle line
      drive(1'b0, 1); drive(1'b1, 24);
      check(n_got == exp_n, "R3 idle glitch", n_got, exp_n);

      // R9: four-tick low pulse is a false start
      drive(1'b0, 4); drive(1'b1, 24);
      check(n_got == exp_n, "R9 false start", n_got, exp_n);
      send_frame(8'h3C, 1'b1, -1); drive(1'b1, 4);
      expect_byte("R9 recover", 8'h3C);

      // R2: no tick means no change
      tick_en = 1'b0;
      repeat (4) @(negedge clk);
      rx_line = 1'b0;
      repeat (40) @(negedge clk);
      check(rx_data == 8'h3C && rx_valid == 1'b0, "R2 hold", rx_data, 8'h3C);
      rx_line = 1'b1;
      repeat (4) @(negedge clk);
      tick_en = 1'b1;
      wait_ticks(24);
      check(n_got == exp_n, "R2 no frame", n_got, exp_n);

      // R6: low stop bit, line held low, then high
      send_frame(8'hA5, 1'b0, -1);
      drive(1'b0, 16);
      drive(1'b1, 40);
      check(n_got == exp_n, "R6 dropped", n_got, exp_n);
      send_frame(8'h96, 1'b1, -1); drive(1'b1, 4);
      expect_byte("R6 recover", 8'h96);

      // R8: sweep across the byte range at a fast tick
      div = 3;
      wait_ticks(4);
      for (int i = 0; i < 52; i++) begin
         send_frame(8'(i * 5), 1'b1, -1);
         drive(1'b1, 4);
         expect_byte("R8 sweep", 8'(i * 5));
      end
      send_frame(8'hFF, 1'b1, -1); drive(1'b1, 4);
      expect_byte("R8 0xFF", 8'hFF);

      // R5: one strobe per frame is implied by the counts; check strobe is low now
      @(negedge clk);
      check(rx_valid == 1'b0, "R5 strobe low", rx_valid, 0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule